// File: doc/BRIEF.md
# Two-Half Load Transmit Word Stack

This block stores outgoing words for a serial link until the serializer sends them. Software, or a receiver acting as a repeater, presents 16-bit halves on a shared parallel bus. A first strobe latches the low half into a holding bank. A second strobe supplies the high half and commits the assembled 31-bit word into an eight-entry fall-through stack. The oldest word always sits in the head position, ready for the serializer.

Loading is possible only while transmit enable is low. While it is high, the stack holds still until the serializer asserts its transfer pulse, and each pulse removes the head word. A synchronous active-low master reset empties everything. Parity generation, bit serialization and the line driver belong to neighbouring blocks.

Top module: `tx_word_stack`

## Requirements
- R1: While `rst_n` is low at a clock edge, the stack, the holding bank and the count are cleared: after that edge `count` is 0, `empty` is 1, `full` is 0 and `head_word` is 0.
- R2: A rising edge of `load_lo` (high now, low in the previous cycle) while `tx_en` is low latches `data_in` as the low half. A later rising edge of `load_lo` before any commit overwrites that low half. If both strobes rise in the same cycle, the low half is taken and the high strobe is ignored.
- R3: A rising edge of `load_hi` while `tx_en` is low commits the word `{data_in[14:0], low_half}`. Bit 15 of the high half is dropped. The commit takes effect one clock later.
- R4: A rising `load_hi` is ignored unless a low half has been latched since the last accepted `load_hi` edge or since reset.
- R5: Words leave in the order they were committed. `head_word` shows the oldest stored word, and shows 0 when the stack is empty.
- R6: The stack holds at most 8 words. A commit while `full` is 1 is discarded: the count and the stored words are unchanged.
- R7: While `tx_en` is high, both strobes are ignored. Nothing is latched and nothing is committed.
- R8: With `tx_en` high, `xfer` high at a clock edge removes the head word when the stack is not empty, and the next word becomes the head after that edge. With an empty stack, `xfer` has no effect.
- R9: While `tx_en` is low, `xfer` has no effect on `head_word` or `count`.
- R10: A strobe held high for several cycles counts as one edge.
- R11: `count` equals the number of stored words. `empty` is 1 exactly when the count is 0, and `full` is 1 exactly when the count is 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| data_in | input | 16 | Parallel half-word bus |
| load_lo | input | 1 | First-half load strobe (rising edge acts) |
| load_hi | input | 1 | Second-half load strobe, commits the word |
| tx_en | input | 1 | Transmit enable; high locks out loads and permits transfers |
| xfer | input | 1 | Serializer transfer request, removes the head word |
| head_word | output | 31 | Oldest stored word |
| count | output | 4 | Number of stored words |
| empty | output | 1 | Stack holds no word |
| full | output | 1 | Stack holds eight words |

## Verification
On every cycle, the embedded assertions check that the count stays within bounds, that no push lands on a full stack and no pop on an empty one, that the count never grows while transmitting, and that the head and count stay put when neither a push nor a pop occurs. Other behaviours can only be shown by the bench's scenarios. These are the assembled bit layout with bit 15 dropped, the overwrite of a repeated low half, the refusal of an unpaired high strobe, the counting of a held strobe as one edge, and the first-in first-out order across a full fill and drain. The bench's reference model checks all of these against the outputs on every cycle.

// File: rtl/tws_pkg.sv
// Shared constants and types for the two-half load transmit word stack.
// Assumes: the strobe index order below is used by the top-level generate loop.
package tws_pkg;
    localparam int DEF_HALF_W  = 16;
    localparam int DEF_WORD_W  = 31;
    localparam int DEF_DEPTH   = 8;

    // Index of each load strobe in the strobe vector
    typedef enum int {
        STB_LO = 0,
        STB_HI = 1
    } strobe_idx_e;

    localparam int NUM_STROBES = 2;
endpackage

// File: rtl/tws_strobe_edge.sv
// Rising-edge detector for one load strobe.
// Assumes: the strobe is already synchronous to clk. The remembered level clears on reset,
// so a strobe that is high in the first cycle after reset counts as an edge.
module tws_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise
);
    logic prev_q;

    // Remember the strobe level of the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= strobe;
    end

    // An edge is high now and low before
    always_comb rise = strobe & ~prev_q;
endmodule

// File: rtl/tws_half_capture.sv
// Holding bank for the low half and the commit decision for the high half.
// Assumes: loads are enabled only while transmission is off. The high half is not stored
// here; it goes straight into the assembled word on the commit cycle.
module tws_half_capture #(
    parameter int HALF_W = 16,
    parameter int WORD_W = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_ok,
    input  logic              lo_rise,
    input  logic              hi_rise,
    input  logic [HALF_W-1:0] data_in,
    output logic              commit,
    output logic [WORD_W-1:0] word
);
    localparam int HI_KEEP = WORD_W - HALF_W;

    logic [HALF_W-1:0] lo_q;
    logic              lo_valid_q;
    logic              lo_take;
    logic              hi_take;

    // Decide which strobe acts this cycle; the low strobe wins a tie
    always_comb begin
        lo_take = load_ok & lo_rise;
        hi_take = load_ok & hi_rise & ~lo_rise;
    end

    // Latch or overwrite the low half on each accepted first strobe
    always_ff @(posedge clk) begin
        if (!rst_n)       lo_q <= '0;
        else if (lo_take) lo_q <= data_in;
    end

    // Track whether a low half is pending since the last second strobe
    always_ff @(posedge clk) begin
        if (!rst_n)       lo_valid_q <= 1'b0;
        else if (lo_take) lo_valid_q <= 1'b1;
        else if (hi_take) lo_valid_q <= 1'b0;
    end

    // Present the assembled word and the commit request
    always_comb begin
        commit = hi_take & lo_valid_q;
        word   = {data_in[HI_KEEP-1:0], lo_q};
    end

    // A pending low half only appears after an accepted first strobe
    AST_LO_PENDING_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_valid_q && !lo_take) |=> !lo_valid_q); // R4
    // Nothing is taken while loading is locked
    AST_LOCKED_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !load_ok |-> !commit); // R7
endmodule

// File: rtl/tws_stack.sv
// Fall-through word store: a push lands in the first empty slot, a pop shifts every slot
// one place toward the head. Slot 0 is the head.
// Assumes: push and pop never occur in the same cycle, and push is gated by full and pop
// by empty upstream. Slots at or above the count always hold zero.
module tws_stack #(
    parameter int WORD_W = 31,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] head,
    output logic [CNT_W-1:0]  count
);
    logic [WORD_W-1:0] slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i == DEPTH - 1) begin : g_top
            // Top slot: filled by a push at the last position, cleared on pop
            always_ff @(posedge clk) begin
                if (!rst_n)                                  slot_q[i] <= '0;
                else if (pop)                                slot_q[i] <= '0;
                else if (push && count == CNT_W'(i))         slot_q[i] <= din;
            end
        end else begin : g_mid
            // Lower slot: takes its upper neighbour on pop, or the new word on push
            always_ff @(posedge clk) begin
                if (!rst_n)                                  slot_q[i] <= '0;
                else if (pop)                                slot_q[i] <= slot_q[i+1];
                else if (push && count == CNT_W'(i))         slot_q[i] <= din;
            end
        end
    end

    // Keep the number of stored words
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (push) count <= count + 1'b1;
        else if (pop)  count <= count - 1'b1;
    end

    // Expose the oldest word
    always_comb head = slot_q[0];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CNT_W'(DEPTH))); // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0)); // R8
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R11
    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (count == CNT_W'($past(count) - 1'b1))); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> ($stable(head) && $stable(count))); // R9
endmodule

// File: rtl/tx_word_stack.sv
// Two-half load transmit word stack: assembles 31-bit words from two strobed 16-bit halves
// and queues up to DEPTH of them for a serializer.
// Assumes: strobes and xfer are synchronous to clk. Loads are meaningful only with tx_en
// low, and transfers only with tx_en high.
module tx_word_stack
    import tws_pkg::*;
#(
    parameter int HALF_W = DEF_HALF_W,
    parameter int WORD_W = DEF_WORD_W,
    parameter int DEPTH  = DEF_DEPTH,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] data_in,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic              tx_en,
    input  logic              xfer,
    output logic [WORD_W-1:0] head_word,
    output logic [CNT_W-1:0]  count,
    output logic              empty,
    output logic              full
);
    logic [NUM_STROBES-1:0] stb_in;
    logic [NUM_STROBES-1:0] stb_rise;
    logic                   commit;
    logic [WORD_W-1:0]      word;
    logic                   push;
    logic                   pop;

    // Gather the strobes in package index order
    always_comb begin
        stb_in         = '0;
        stb_in[STB_LO] = load_lo;
        stb_in[STB_HI] = load_hi;
    end

    for (genvar s = 0; s < NUM_STROBES; s++) begin : g_edge
        tws_strobe_edge u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .strobe (stb_in[s]),
            .rise   (stb_rise[s])
        );
    end

    tws_half_capture #(
        .HALF_W (HALF_W),
        .WORD_W (WORD_W)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_ok (~tx_en),
        .lo_rise (stb_rise[STB_LO]),
        .hi_rise (stb_rise[STB_HI]),
        .data_in (data_in),
        .commit  (commit),
        .word    (word)
    );

    // Gate the push by fullness and the pop by enable and emptiness
    always_comb begin
        push = commit & ~full;
        pop  = tx_en & xfer & ~empty;
    end

    tws_stack #(
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH)
    ) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (word),
        .head  (head_word),
        .count (count)
    );

    // Derive the level flags from the count
    always_comb begin
        empty = (count == '0);
        full  = (count == CNT_W'(DEPTH));
    end

    AST_TX_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |=> (count <= $past(count))); // R7
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !tx_en) |=> full); // R6
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full)); // R11
endmodule

// File: tb/tx_word_stack_tb.sv
`timescale 1ns/1ps
module tx_word_stack_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] data_in = '0;
    logic        load_lo = 1'b0;
    logic        load_hi = 1'b0;
    logic        tx_en = 1'b0;
    logic        xfer = 1'b0;
    logic [30:0] head_word;
    logic [3:0]  count;
    logic        empty;
    logic        full;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cycles = 0;
    bit    timed_out = 1'b0;
    string cur_req = "R1";

    // Reference model state
    logic [30:0] q[$];
    logic [15:0] m_lo = '0;
    bit          m_lov = 1'b0;
    bit          m_plo = 1'b0;
    bit          m_phi = 1'b0;

    always #4 clk = ~clk;

    tx_word_stack u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_in   (data_in),
        .load_lo   (load_lo),
        .load_hi   (load_hi),
        .tx_en     (tx_en),
        .xfer      (xfer),
        .head_word (head_word),
        .count     (count),
        .empty     (empty),
        .full      (full)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Behavioural model of the requirements, stepped on each rising edge
    always @(posedge clk) begin
        bit elo, ehi;
        if (!rst_n) begin
            q.delete();
            m_lo = '0; m_lov = 0; m_plo = 0; m_phi = 0;
        end else begin
            elo = load_lo && !m_plo;
            ehi = load_hi && !m_phi;
            m_plo = load_lo;
            m_phi = load_hi;
            if (!tx_en) begin
                if (elo) begin
                    m_lo = data_in; m_lov = 1;
                end else if (ehi) begin
                    if (m_lov && q.size() < 8) q.push_back({data_in[14:0], m_lo});
                    m_lov = 0;
                end
            end else if (xfer && q.size() > 0) begin
                void'(q.pop_front());
            end
        end
    end

    // Compare every output against the model away from the active edge
    always @(negedge clk) begin
        logic [30:0] eh;
        cycles++;
        if (cycles > 50000) timed_out = 1'b1;
        eh = (q.size() > 0) ? q[0] : '0;
        chk(cur_req, "count R11", 32'(count), 32'(q.size()));
        chk(cur_req, "head R5", 32'(head_word), 32'(eh));
        chk(cur_req, "empty R11", 32'(empty), 32'(q.size() == 0));
        chk(cur_req, "full R11", 32'(full), 32'(q.size() == 8));
    end

    task automatic strobe_lo(input logic [15:0] d, input int hold = 1);
        @(negedge clk); data_in = d; load_lo = 1'b1;
        repeat (hold - 1) @(negedge clk);
        @(negedge clk); load_lo = 1'b0;
    endtask

    task automatic strobe_hi(input logic [15:0] d, input int hold = 1);
        @(negedge clk); data_in = d; load_hi = 1'b1;
        repeat (hold - 1) @(negedge clk);
        @(negedge clk); load_hi = 1'b0;
    endtask

    task automatic pulse_xfer();
        @(negedge clk); xfer = 1'b1;
        @(negedge clk); xfer = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk); @(negedge clk);
    endtask

    initial begin
        fork
            begin
                // R1: reset state
                cur_req = "R1";
                repeat (3) @(negedge clk);
                chk("R1", "count", 32'(count), 0);
                chk("R1", "empty", 32'(empty), 1);
                chk("R1", "full", 32'(full), 0);
                chk("R1", "head", 32'(head_word), 0);
                rst_n = 1'b1;

                // R2 overwrite of the low half, R3 assembly with bit 15 dropped
                cur_req = "R2";
                strobe_lo(16'h1234);
                strobe_lo(16'hABCD);
                cur_req = "R3";
                strobe_hi(16'hC001);
                settle();
                chk("R3", "assembled head", 32'(head_word), 32'h4001ABCD);
                chk("R2", "count after one commit", 32'(count), 1);

                // R4: unpaired second strobe ignored
                cur_req = "R4";
                strobe_hi(16'h5555);
                settle();
                chk("R4", "count after lone high strobe", 32'(count), 1);

                // R10: held strobes act once
                cur_req = "R10";
                strobe_lo(16'h0002, 3);
                strobe_hi(16'h0003, 3);
                settle();
                chk("R10", "count after held strobes", 32'(count), 2);

                // R6: fill to capacity, then an extra word is discarded
                cur_req = "R6";
                for (int k = 2; k < 8; k++) begin
                    strobe_lo(16'(k * 16'h0101));
                    strobe_hi(16'(k));
                end
                settle();
                chk("R6", "full at capacity", 32'(full), 1);
                strobe_lo(16'hFFFF);
                strobe_hi(16'h7777);
                settle();
                chk("R6", "count after commit on full", 32'(count), 8);
                chk("R6", "head unchanged on full", 32'(head_word), 32'h4001ABCD);

                // R9: transfer request with enable low
                cur_req = "R9";
                pulse_xfer();
                settle();
                chk("R9", "count after idle xfer", 32'(count), 8);
                chk("R9", "head after idle xfer", 32'(head_word), 32'h4001ABCD);

                // R7: loads locked while transmitting
                cur_req = "R7";
                @(negedge clk); tx_en = 1'b1;
                strobe_lo(16'h1111);
                strobe_hi(16'h2222);
                settle();
                chk("R7", "count with loads during tx", 32'(count), 8);

                // R8 and R5: drain in commit order, then a pop on empty
                cur_req = "R8";
                pulse_xfer();
                settle();
                chk("R5", "second word at head", 32'(head_word), 32'h00030002);
                chk("R8", "count after one pop", 32'(count), 7);
                for (int k = 0; k < 8; k++) pulse_xfer();
                settle();
                chk("R8", "empty after drain", 32'(empty), 1);
                chk("R8", "head zero when empty", 32'(head_word), 0);

                // R7: low half offered during tx was not latched
                cur_req = "R7";
                @(negedge clk); tx_en = 1'b1;
                strobe_lo(16'h4444);
                @(negedge clk); tx_en = 1'b0;
                strobe_hi(16'h0001);
                settle();
                chk("R7", "no commit from locked low half", 32'(count), 0);

                // R1: reset in the middle of use
                cur_req = "R1";
                strobe_lo(16'h0BAD);
                strobe_hi(16'h0001);
                strobe_lo(16'h0CAB);
                @(negedge clk); rst_n = 1'b0;
                @(negedge clk); rst_n = 1'b1;
                strobe_hi(16'h0002);
                settle();
                chk("R1", "count after reset", 32'(count), 0);
                chk("R1", "head after reset", 32'(head_word), 0);
            end
            begin
                wait (timed_out);
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule